// File: doc/BRIEF.md
# Control-Steered Single-Track Token Split

This block is a clocked behavioural model of a one-input, two-output routing stage for single-track channels. Each channel is a small group of wires shared by its sender and its receiver. The sender places a token by raising exactly one wire of an empty channel. The receiver takes the token away by clearing every wire of that channel. An all-low channel is empty. The data input carries a 1-of-N token, and a separate 1-of-2 steering channel tells the stage where that token goes.

When a valid data token and a valid steering token are both present, the stage checks only the output that the steering value selects. If that output is empty, the stage copies the data token onto it and clears both input channels on the same clock edge. The steering token is therefore consumed, not just sampled. An occupied output that was not selected never stalls the stage. If an input channel has more than one wire high, the stage reports it on an error flag and refuses to forward.

The wires are modelled as registers inside the stage. Each one can be set by its sender and cleared by its receiver, and both actions act on the next rising clock edge.

Top module: `st_split`

## Requirements
- R1: After reset, every channel wire (data in, steering, both outputs) is low and both error flags are low.
- R2: Steering wire pattern 2'b01 (rail 0 high) routes the data token to output A, and pattern 2'b10 (rail 1 high) routes it to output B. The output receives the data token's rail pattern unchanged.
- R3: Nothing is forwarded unless the data channel holds exactly one high wire and the steering channel holds exactly one high wire.
- R4: While the selected output holds a token, the data and steering tokens stay on their wires unchanged and that output keeps its token.
- R5: A token held on the output that was not selected does not prevent forwarding to the selected output.
- R6: On the edge that loads the selected output, the data and steering channels both become empty.
- R7: A data or steering channel with two or more wires high raises its error flag (data_err / ctl_err) as long as the pattern stays. It is never forwarded and never cleared by the stage.
- R8: A sender's set request loads its channel on the next edge only when that channel is empty. A request against an occupied channel has no effect.
- R9: A receiver clear request empties an occupied output on the next edge.
- R10: A token set at an edge with the other input already present and the selected output empty appears on that output one edge later. Total latency is two edges from the set request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_set_i | input | DATA_RAILS | Data sender's rail pattern to place on an empty data channel |
| c_set_i | input | 2 | Steering sender's rail pattern to place on an empty steering channel |
| ra_clr_i | input | 1 | Output A receiver consumes its token |
| rb_clr_i | input | 1 | Output B receiver consumes its token |
| l_wire_o | output | DATA_RAILS | Current data channel wires |
| c_wire_o | output | 2 | Current steering channel wires |
| ra_wire_o | output | DATA_RAILS | Current output A wires |
| rb_wire_o | output | DATA_RAILS | Current output B wires |
| data_err_o | output | 1 | Data channel holds more than one high wire |
| ctl_err_o | output | 1 | Steering channel holds more than one high wire |

## Verification
The bench builds the stage with DATA_RAILS = 2, the dual-rail width, so every legal token, the empty pattern and the single illegal pattern 2'b11 can all be driven on the data channel. With two rails the random phase quickly reaches the important overlaps: the selected output full while the other one is empty, a clear and a forward aimed at the same output in one cycle, and set requests against occupied channels. Illegal patterns are driven only in a directed phase that ends in a reset, because the stage holds them indefinitely.

// File: rtl/st_split_pkg.sv
package st_split_pkg;

    localparam int unsigned CTL_RAILS = 2;

    typedef enum logic [CTL_RAILS-1:0] {
        STEER_NONE = 2'b00,
        STEER_A    = 2'b01,
        STEER_B    = 2'b10,
        STEER_BAD  = 2'b11
    } steer_e;

endpackage

// File: rtl/st_tok_class.sv
module st_tok_class #(
    parameter int unsigned RAILS = 2
) (
    input  logic [RAILS-1:0] tok_i,
    output logic             valid_o,
    output logic             bad_o
);
    localparam int unsigned CW = $clog2(RAILS + 1);

    logic [CW-1:0] hot_cnt;

    always_comb begin
        hot_cnt = '0;
        for (int i = 0; i < RAILS; i++) begin
            hot_cnt = hot_cnt + CW'(tok_i[i]);
        end
    end

    assign valid_o = (hot_cnt == CW'(1));
    assign bad_o   = (hot_cnt > CW'(1));
endmodule

// File: rtl/st_split_steer.sv
module st_split_steer (
    input  logic data_ok_i,
    input  logic ctl_ok_i,
    input  logic sel_b_i,
    input  logic a_busy_i,
    input  logic b_busy_i,
    output logic fire_a_o,
    output logic fire_b_o
);
    logic both_here;

    assign both_here = data_ok_i & ctl_ok_i;
    assign fire_a_o  = both_here & ~sel_b_i & ~a_busy_i;
    assign fire_b_o  = both_here &  sel_b_i & ~b_busy_i;
endmodule

// File: rtl/st_split.sv
module st_split #(
    parameter int unsigned DATA_RAILS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DATA_RAILS-1:0] l_set_i,
    input  logic [1:0]            c_set_i,
    input  logic                  ra_clr_i,
    input  logic                  rb_clr_i,
    output logic [DATA_RAILS-1:0] l_wire_o,
    output logic [1:0]            c_wire_o,
    output logic [DATA_RAILS-1:0] ra_wire_o,
    output logic [DATA_RAILS-1:0] rb_wire_o,
    output logic                  data_err_o,
    output logic                  ctl_err_o
);
    import st_split_pkg::*;

    localparam int unsigned DW = DATA_RAILS;
    localparam int unsigned CW = CTL_RAILS;

    typedef struct packed {
        logic [DW-1:0] l;
        logic [CW-1:0] c;
        logic [DW-1:0] ra;
        logic [DW-1:0] rb;
    } wires_t;

    wires_t st_d, st_q;

    logic data_ok, data_bad, ctl_ok, ctl_bad;
    logic fire_a, fire_b, fire_any;
    logic sel_b;

    st_tok_class #(.RAILS(DW)) u_data_class (
        .tok_i   (st_q.l),
        .valid_o (data_ok),
        .bad_o   (data_bad)
    );

    st_tok_class #(.RAILS(CW)) u_ctl_class (
        .tok_i   (st_q.c),
        .valid_o (ctl_ok),
        .bad_o   (ctl_bad)
    );

    assign sel_b = (steer_e'(st_q.c) == STEER_B);

    st_split_steer u_steer (
        .data_ok_i (data_ok),
        .ctl_ok_i  (ctl_ok),
        .sel_b_i   (sel_b),
        .a_busy_i  (|st_q.ra),
        .b_busy_i  (|st_q.rb),
        .fire_a_o  (fire_a),
        .fire_b_o  (fire_b)
    );

    assign fire_any = fire_a | fire_b;

    always_comb begin
        st_d = st_q;

        if (fire_any) begin
            st_d.l = '0;
        end else if (st_q.l == '0) begin
            st_d.l = l_set_i;
        end

        if (fire_any) begin
            st_d.c = '0;
        end else if (st_q.c == '0) begin
            st_d.c = c_set_i;
        end

        if (fire_a) begin
            st_d.ra = st_q.l;
        end else if (ra_clr_i) begin
            st_d.ra = '0;
        end

        if (fire_b) begin
            st_d.rb = st_q.l;
        end else if (rb_clr_i) begin
            st_d.rb = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_wire_o   = st_q.l;
    assign c_wire_o   = st_q.c;
    assign ra_wire_o  = st_q.ra;
    assign rb_wire_o  = st_q.rb;
    assign data_err_o = data_bad;
    assign ctl_err_o  = ctl_bad;
endmodule

// File: rtl/st_split_chk.sv
module st_split_chk #(
    parameter int unsigned DATA_RAILS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ra_clr_i,
    input logic                  rb_clr_i,
    input logic [DATA_RAILS-1:0] l_wire_o,
    input logic [1:0]            c_wire_o,
    input logic [DATA_RAILS-1:0] ra_wire_o,
    input logic [DATA_RAILS-1:0] rb_wire_o,
    input logic                  data_err_o
);
    // Outputs only ever receive single-rail tokens (R2, R7)
    assert_out_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ra_wire_o) && $onehot0(rb_wire_o));

    // A newly loaded output A coincides with empty inputs (R6)
    assert_fwd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|l_wire_o && !(|ra_wire_o) && c_wire_o == 2'b01) |=>
        (|ra_wire_o) ? (l_wire_o == '0 && c_wire_o == 2'b00) : 1'b1);

    // Selected output busy and not cleared: everything holds (R4)
    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|l_wire_o && c_wire_o == 2'b10 && |rb_wire_o && !rb_clr_i) |=>
        ($stable(l_wire_o) && $stable(rb_wire_o) && $stable(c_wire_o)));

    // Illegal data pattern stays put (R7)
    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_err_o |=> $stable(l_wire_o));

    // Receiver clear empties an occupied output (R9)
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ra_wire_o && ra_clr_i) |=> (ra_wire_o == '0));
endmodule

bind st_split st_split_chk #(.DATA_RAILS(DATA_RAILS)) u_st_split_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_clr_i   (ra_clr_i),
    .rb_clr_i   (rb_clr_i),
    .l_wire_o   (l_wire_o),
    .c_wire_o   (c_wire_o),
    .ra_wire_o  (ra_wire_o),
    .rb_wire_o  (rb_wire_o),
    .data_err_o (data_err_o)
);

// File: tb/test_st_split.sv
module test_st_split;
    localparam int unsigned N = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] l_set = '0;
    logic [1:0]   c_set = '0;
    logic ra_clr = 1'b0, rb_clr = 1'b0;
    logic [N-1:0] l_w, ra_w, rb_w;
    logic [1:0]   c_w;
    logic d_err, c_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [N-1:0] mL = '0, mA = '0, mB = '0;
    logic [1:0]   mC = '0;

    always #2.5 clk = ~clk;

    st_split #(.DATA_RAILS(N)) i_st_split (
        .clk(clk), .rst_n(rst_n),
        .l_set_i(l_set), .c_set_i(c_set),
        .ra_clr_i(ra_clr), .rb_clr_i(rb_clr),
        .l_wire_o(l_w), .c_wire_o(c_w),
        .ra_wire_o(ra_w), .rb_wire_o(rb_w),
        .data_err_o(d_err), .ctl_err_o(c_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 output A", 8'(ra_w), 8'(mA));
        chk("R2 output B", 8'(rb_w), 8'(mB));
        chk("R6 data wire", 8'(l_w), 8'(mL));
        chk("R6 steer wire", 8'(c_w), 8'(mC));
        chk("R7 data err", 8'(d_err), 8'($countones(mL) > 1));
        chk("R7 steer err", 8'(c_err), 8'($countones(mC) > 1));
    endtask

    // apply inputs for one cycle, advance model and compare at the next negedge
    task automatic step(input logic [N-1:0] ls, input logic [1:0] cs,
                        input logic ca, input logic cb);
        bit lv, cv, fa, fb;
        l_set = ls; c_set = cs; ra_clr = ca; rb_clr = cb;
        lv = ($countones(mL) == 1);
        cv = ($countones(mC) == 1);
        fa = lv && cv && (mC == 2'b01) && (mA == '0);
        fb = lv && cv && (mC == 2'b10) && (mB == '0);
        if (fa) mA = mL; else if (ca) mA = '0;
        if (fb) mB = mL; else if (cb) mB = '0;
        if (fa || fb) begin
            mL = '0; mC = '0;
        end else begin
            if (mL == '0) mL = ls;
            if (mC == '0) mC = cs;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; l_set = '0; c_set = '0; ra_clr = 1'b0; rb_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mL = '0; mC = '0; mA = '0; mB = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 data wire", 8'(l_w), 8'h0);
        chk("R1 steer wire", 8'(c_w), 8'h0);
        chk("R1 out A", 8'(ra_w), 8'h0);
        chk("R1 out B", 8'(rb_w), 8'h0);
        chk("R1 errors", 8'({d_err, c_err}), 8'h0);

        // R3: data alone does not forward
        step(2'b01, 2'b00, 1'b0, 1'b0);
        step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R3 no forward without steer", 8'(ra_w | rb_w), 8'h0);
        // R8: set on an occupied data wire has no effect
        step(2'b10, 2'b00, 1'b0, 1'b0);
        chk("R8 occupied data kept", 8'(l_w), 8'h01);
        // R10: steer arrives, appears after one edge, forwarded the next
        step(2'b00, 2'b01, 1'b0, 1'b0);
        chk("R10 steer loaded", 8'(c_w), 8'h01);
        chk("R10 not yet forwarded", 8'(ra_w), 8'h0);
        step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R2 rail0 steer to A", 8'(ra_w), 8'h01);
        chk("R6 inputs cleared", 8'({l_w, c_w}), 8'h0);

        // R4: A busy, next token steered to A waits
        step(2'b10, 2'b01, 1'b0, 1'b0);
        repeat (3) step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R4 data waits", 8'(l_w), 8'h02);
        chk("R4 A holds", 8'(ra_w), 8'h01);
        // R9: clear A, then the waiting token goes through
        step(2'b00, 2'b00, 1'b1, 1'b0);
        chk("R9 A cleared", 8'(ra_w), 8'h0);
        step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R4 released to A", 8'(ra_w), 8'h02);

        // R5: A busy, steer to B still forwards
        step(2'b01, 2'b10, 1'b0, 1'b0);
        step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R5 B loaded despite busy A", 8'(rb_w), 8'h01);
        chk("R5 A untouched", 8'(ra_w), 8'h02);
        step(2'b00, 2'b00, 1'b1, 1'b1);

        // random legal traffic
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] ls;
            logic [1:0]   cs;
            int r;
            r = $urandom_range(0, 2);
            ls = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
            r = $urandom_range(0, 2);
            cs = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b10;
            step(ls, cs, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
        end

        // R7: illegal data pattern
        do_reset();
        step(2'b11, 2'b01, 1'b0, 1'b0);
        repeat (3) step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R7 data error flag", 8'(d_err), 8'h1);
        chk("R7 no forward on bad data", 8'(ra_w), 8'h0);
        chk("R7 bad data held", 8'(l_w), 8'h03);
        // R7: illegal steering pattern
        do_reset();
        step(2'b10, 2'b11, 1'b0, 1'b0);
        repeat (3) step(2'b00, 2'b00, 1'b0, 1'b0);
        chk("R7 steer error flag", 8'(c_err), 8'h1);
        chk("R7 no forward on bad steer", 8'(ra_w | rb_w), 8'h0);
        do_reset();
        compare_all();

        finish_run();
    end
endmodule